// File: doc/BRIEF.md
# Two-Entry-Per-Word Color Lookup Table

This block holds a color lookup table of 256 entries in 128 words of 32 bits. Each word carries two 16-bit entries. An entry is a 15-bit color with five bits each for red, green and blue, plus one intensity bit that the block stores but does not use. A processor-side port writes and reads whole words by word index. The stored word comes back unchanged.

A pixel-side port takes an 8-bit entry index and a depth-format code. One clock later it returns the entry as 24-bit true color, with each 5-bit channel widened to 8 bits. In the same cycle it also returns a reduced-depth repacking of that color in the format the code selects. The format can be RGB332, RGB555 or RGB565.

Typical use: software loads the table through the word port. A pixel pipeline then feeds one index per cycle and picks whichever output matches its frame buffer depth.

Top module: `clut_pack_ram`

## Requirements
- R1: Bit 0 of the pixel index selects the half of word `pix_idx[7:1]`. A 0 selects bits [15:0] and a 1 selects bits [31:16].
- R2: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Each channel is shifted left by 3 with zero fill. `rgb24` is {red, green, blue}, with red in bits [23:16].
- R3: Entry bit 15 (intensity) has no effect on `rgb24` or `pix_packed`.
- R4: Format code 2'b00 gives RGB332. `pix_packed[7:0]` = {r[7:5], g[7:5], b[7:6]} of the widened channels, and `pix_packed[15:8]` = 0.
- R5: Format code 2'b01 gives RGB555. `pix_packed` = {1'b0, r[7:3], g[7:3], b[7:3]}.
- R6: Format code 2'b10 gives RGB565. `pix_packed` = {r[7:3], g[7:2], b[7:3]}.
- R7: Format code 2'b11 is reserved and drives `pix_packed` to zero.
- R8: `rgb24` and `pix_packed` reflect the index and format sampled at the previous rising clock edge.
- R9: If a bus write and a pixel lookup hit the same word at the same edge, the lookup returns the data held before the write.
- R10: `bus_rdata` is the raw stored word at `bus_addr`, one cycle later. A read and a write to the same word at the same edge return the old word.
- R11: While reset is asserted, `rgb24`, `pix_packed` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Word write enable |
| bus_addr | input | 7 | Word index for read and write |
| bus_wdata | input | 32 | Word write data |
| bus_rdata | output | 32 | Registered word read data |
| pix_idx | input | 8 | Entry index for lookup |
| pix_fmt | input | 2 | Reduced-depth format code |
| rgb24 | output | 24 | Widened color {r,g,b} |
| pix_packed | output | 16 | Color repacked to the selected format |

## Verification
The hardest case to reach is a write and a lookup of the same word at the same edge, because the two ports must be lined up on one cycle. The stimulus sets the write address, new data and a pixel index inside that word at the same falling edge. It then checks the old color first and the new color one cycle later. The intensity bit is covered by rewriting a word with only bit 15 of an entry changed and comparing the outputs across all four format codes.

// File: rtl/clut_pack_pkg.sv
package clut_pack_pkg;
  localparam int CH_IN_W   = 5;
  localparam int CH_OUT_W  = 8;
  localparam int ENTRY_W   = 16;
  localparam int PER_WORD  = 2;
  localparam int WORD_W    = ENTRY_W * PER_WORD;
  localparam int N_WORDS   = 128;
  localparam int RGB_W     = 3 * CH_OUT_W;
  localparam int PACK_W    = 16;

  typedef enum logic [1:0] {
    FMT_RGB332 = 2'b00,
    FMT_RGB555 = 2'b01,
    FMT_RGB565 = 2'b10,
    FMT_OFF    = 2'b11
  } depth_fmt_e;
endpackage

// File: rtl/clut_word_store.sv
module clut_word_store #(
  parameter int WORDS = 128,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] bus_q,
  input  logic [AW-1:0] pix_addr,
  output logic [DW-1:0] pix_q
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[bus_addr] <= wdata;
    end
  end

  // both read ports sample before the write lands: old data on collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      pix_q <= '0;
    end else begin
      bus_q <= mem[bus_addr];
      pix_q <= mem[pix_addr];
    end
  end
endmodule

// File: rtl/clut_expand.sv
module clut_expand
  import clut_pack_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  output logic [RGB_W-1:0]   rgb
);
  localparam int PAD = CH_OUT_W - CH_IN_W;

  // channel k of the entry lands in byte (2-k) of the output
  for (genvar k = 0; k < 3; k++) begin : g_ch
    logic [CH_IN_W-1:0] raw;
    assign raw = entry[k*CH_IN_W +: CH_IN_W];
    assign rgb[(2-k)*CH_OUT_W +: CH_OUT_W] = {raw, {PAD{1'b0}}};
  end
endmodule

// File: rtl/clut_repack.sv
module clut_repack
  import clut_pack_pkg::*;
(
  input  logic [RGB_W-1:0]  rgb,
  input  depth_fmt_e        fmt,
  output logic [PACK_W-1:0] packed_px
);
  logic [CH_OUT_W-1:0] r, g, b;
  assign r = rgb[2*CH_OUT_W +: CH_OUT_W];
  assign g = rgb[CH_OUT_W +: CH_OUT_W];
  assign b = rgb[0 +: CH_OUT_W];

  always_comb begin
    unique case (fmt)
      FMT_RGB332: packed_px = {8'h00, r[7:5], g[7:5], b[7:6]};
      FMT_RGB555: packed_px = {1'b0, r[7:3], g[7:3], b[7:3]};
      FMT_RGB565: packed_px = {r[7:3], g[7:2], b[7:3]};
      default:    packed_px = '0;
    endcase
  end
endmodule

// File: rtl/clut_pack_ram.sv
module clut_pack_ram
  import clut_pack_pkg::*;
#(
  parameter int WORDS = N_WORDS,
  localparam int AW   = $clog2(WORDS),
  localparam int IW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [IW-1:0]     pix_idx,
  input  logic [1:0]        pix_fmt,
  output logic [RGB_W-1:0]  rgb24,
  output logic [PACK_W-1:0] pix_packed
);
  logic [WORD_W-1:0]  pix_word;
  logic               half_d, half_q;
  depth_fmt_e         fmt_d, fmt_q;
  logic [ENTRY_W-1:0] entry;

  clut_word_store #(.WORDS(WORDS), .DW(WORD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .bus_addr (bus_addr),
    .wdata    (bus_wdata),
    .bus_q    (bus_rdata),
    .pix_addr (pix_idx[IW-1:1]),
    .pix_q    (pix_word)
  );

  always_comb begin
    half_d = pix_idx[0];
    fmt_d  = depth_fmt_e'(pix_fmt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      fmt_q  <= FMT_RGB332;
    end else begin
      half_q <= half_d;
      fmt_q  <= fmt_d;
    end
  end

  assign entry = half_q ? pix_word[WORD_W-1:ENTRY_W] : pix_word[ENTRY_W-1:0];

  clut_expand u_expand (
    .entry (entry),
    .rgb   (rgb24)
  );

  clut_repack u_repack (
    .rgb       (rgb24),
    .fmt       (fmt_q),
    .packed_px (pix_packed)
  );
endmodule

// File: rtl/clut_pack_ram_chk.sv
module clut_pack_ram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [6:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [1:0]  pix_fmt,
  input logic [23:0] rgb24,
  input logic [15:0] pix_packed
);
  // R10
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we ##1 (bus_addr == $past(bus_addr)) |=> bus_rdata == $past(bus_wdata, 2));

  // R2
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb24[2:0] == 3'b0) && (rgb24[10:8] == 3'b0) && (rgb24[18:16] == 3'b0));

  // R4
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fmt == 2'b00) |=> pix_packed[15:8] == 8'h00);

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fmt == 2'b11) |=> pix_packed == 16'h0000);

  // R6
  wide_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fmt == 2'b10) |=> pix_packed == {rgb24[23:19], rgb24[15:10], rgb24[7:3]});
endmodule

bind clut_pack_ram clut_pack_ram_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pix_fmt    (pix_fmt),
  .rgb24      (rgb24),
  .pix_packed (pix_packed)
);

// File: tb/clut_pack_ram_tb.sv
module clut_pack_ram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NLOOK = 12;
  // {fmt[1:0], idx[7:0]}
  localparam logic [9:0] LOOKS [NLOOK] = '{
    {2'b00, 8'd0},   {2'b01, 8'd1},   {2'b10, 8'd2},   {2'b11, 8'd3},
    {2'b00, 8'd77},  {2'b01, 8'd128}, {2'b10, 8'd129}, {2'b10, 8'd254},
    {2'b01, 8'd255}, {2'b00, 8'd200}, {2'b11, 8'd17},  {2'b10, 8'd64}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx;
  logic [1:0]  pix_fmt;
  logic [23:0] rgb24;
  logic [15:0] pix_packed;

  logic [31:0] shadow [128];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clut_pack_ram dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx),
    .pix_fmt(pix_fmt), .rgb24(rgb24), .pix_packed(pix_packed)
  );

  function automatic logic [23:0] exp_rgb(input logic [15:0] e);
    return {e[4:0], 3'b0, e[9:5], 3'b0, e[14:10], 3'b0};
  endfunction

  function automatic logic [15:0] exp_pack(input logic [15:0] e, input logic [1:0] f);
    logic [7:0] r, g, b;
    r = {e[4:0], 3'b0}; g = {e[9:5], 3'b0}; b = {e[14:10], 3'b0};
    case (f)
      2'b00:   return {8'h00, r[7:5], g[7:5], b[7:6]};
      2'b01:   return {1'b0, r[7:3], g[7:3], b[7:3]};
      2'b10:   return {r[7:3], g[7:2], b[7:3]};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] entry_of(input logic [7:0] idx);
    return idx[0] ? shadow[idx[7:1]][31:16] : shadow[idx[7:1]][15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    shadow[a] = d;
  endtask

  task automatic look(input string req, input logic [7:0] idx, input logic [1:0] f);
    logic [15:0] e;
    @(negedge clk);
    pix_idx = idx; pix_fmt = f;
    e = entry_of(idx);
    @(negedge clk);
    check(req, {8'h0, rgb24}, {8'h0, exp_rgb(e)});
    check(req, {16'h0, pix_packed}, {16'h0, exp_pack(e, f)});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pix_idx = '0; pix_fmt = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {8'h0, rgb24}, 32'h0);
    check("R11", {16'h0, pix_packed}, 32'h0);
    check("R11", bus_rdata, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 128; i++)
      wr(7'(i), (32'(i) * 32'h9E3779B1) ^ 32'hA5C30F96);

    // R10 raw readback
    for (int i = 0; i < 128; i += 9) begin
      @(negedge clk);
      bus_addr = 7'(i);
      @(negedge clk);
      check("R10", bus_rdata, shadow[i]);
    end

    // R1 R2 R4 R5 R6 R7 R8 vector table
    foreach (LOOKS[k])
      look("R1/R2/R4-R8", LOOKS[k][7:0], LOOKS[k][9:8]);

    // R2 pure channels: red only, green only, blue only
    wr(7'd10, {16'h03E0, 16'h001F});
    wr(7'd11, {16'h0000, 16'h7C00});
    look("R2", 8'd20, 2'b10);
    look("R2", 8'd21, 2'b01);
    look("R2", 8'd22, 2'b00);

    // R3 intensity bit toggled in both halves
    wr(7'd40, {16'h1234 & 16'h7FFF, 16'h5A5A & 16'h7FFF});
    for (int f = 0; f < 4; f++) look("R3", 8'd80, 2'(f));
    for (int f = 0; f < 4; f++) look("R3", 8'd81, 2'(f));
    begin
      logic [23:0] ref_rgb;
      logic [15:0] ref_pk;
      ref_rgb = exp_rgb(16'h5A5A & 16'h7FFF);
      wr(7'd40, {16'h1234 | 16'h8000, 16'h5A5A | 16'h8000});
      for (int f = 0; f < 4; f++) begin
        @(negedge clk); pix_idx = 8'd80; pix_fmt = 2'(f);
        @(negedge clk);
        ref_pk = exp_pack(16'h5A5A, 2'(f));
        check("R3", {8'h0, rgb24}, {8'h0, ref_rgb});
        check("R3", {16'h0, pix_packed}, {16'h0, ref_pk});
      end
    end

    // R9 R10 same-edge write and lookup/read of one word
    begin
      logic [31:0] old_w, new_w;
      old_w = shadow[99];
      new_w = 32'h0421_7BDE;
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 7'd99; bus_wdata = new_w;
      pix_idx = 8'd199; pix_fmt = 2'b10;
      @(negedge clk);
      bus_we = 1'b0;
      shadow[99] = new_w;
      check("R9", {8'h0, rgb24}, {8'h0, exp_rgb(old_w[31:16])});
      check("R9", {16'h0, pix_packed}, {16'h0, exp_pack(old_w[31:16], 2'b10)});
      check("R10", bus_rdata, old_w);
      @(negedge clk);
      check("R9", {8'h0, rgb24}, {8'h0, exp_rgb(new_w[31:16])});
      check("R10", bus_rdata, new_w);
    end

    // R8 output holds previous cycle's index until the next edge
    @(negedge clk); pix_idx = 8'd0; pix_fmt = 2'b01;
    @(negedge clk);
    pix_idx = 8'd255; pix_fmt = 2'b11;
    #1;
    check("R8", {16'h0, pix_packed}, {16'h0, exp_pack(entry_of(8'd0), 2'b01)});
    @(negedge clk);
    check("R8", {16'h0, pix_packed}, 32'h0);

    // R11 reset mid-run clears outputs
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R11", {8'h0, rgb24}, 32'h0);
    check("R11", bus_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule